// File: doc/BRIEF.md
# Adaptive Bit Sampling Tracker for a Low/Full-Speed USB Line

This block follows the bit timing of a USB low-speed or full-speed line that is sampled by a fast clock. The line state comes in as the raw D+/D- pair, one value per clock. A start-of-packet pulse arrives on the clock where the first K shows. On that pulse the block sets its phase so that the first mid-bit sample falls about one bit period later. From then on it raises a mid-bit strobe once per bit, with the line value captured there. It also raises an edge-point strobe half a bit ahead of each sample, with the line value captured at that point.

Position and period are kept in fixed point. At every mid-bit sample where the symbol differs from the previous one, the block looks at the state captured at the edge point. If the line had already switched there, the far end runs fast, so the period shrinks by 0.1% and the next sample moves earlier by 1% of a bit. If it had not switched, the period grows and the sample moves later. The period stays within 5% of nominal. An end-of-packet pulse stops the strobes and restores the nominal period. Symbol decoding and bit destuffing are left to the logic that follows.

Top module: `usb_bit_tracker`

## Requirements
- R1: After reset both strobes are low and the period output equals the nominal period. The nominal period is OVS_KHZ·2^FRAC_W / bit rate in kHz, where the bit rate is 12000 kHz for full speed and 1500 kHz for low speed. This gives 2048 with the defaults (96 MHz clock, full speed, FRAC_W = 8).
- R2: A start-of-packet pulse seen at clock edge n places the first sample point at fixed-point position n·2^FRAC_W − floor(P/2) + 2^(FRAC_W−1) + P, where P is the period. The mid-bit strobe is registered at the edge where the counter equals the integer part of that position, which is edge n+4 with the defaults.
- R3: Each later sample point is the previous one plus P, plus or minus the phase step. Half a bit before it, at the integer part of (previous point + P − floor(P/2)), the edge-point strobe fires and edge_line_o takes the line value. smp_line_o takes the line value at each sample point. The two strobes never fire together.
- R4: At a sample whose symbol differs from the previous sample, if the edge-point state equals the new symbol, then P' = max(P − floor(P/1000), Pmin) and the next point moves earlier by floor(P'/100).
- R5: In the same situation with an edge-point state that differs from the new symbol, P' = min(P + floor(P/1000), Pmax) and the next point moves later by floor(P'/100).
- R6: No trim is made when the new symbol or the edge-point state is single-ended (line value 00 = SE0 or 11 = SE1; bit 1 is D+, bit 0 is D-), or when the symbol did not change. The period output changes only in the cycle its mid-bit strobe is raised, or after an end of packet.
- R7: The period always lies between Pmin = N − floor(N/20) and Pmax = N + floor(N/20), where N is the nominal period.
- R8: An end-of-packet pulse stops both strobes from the next edge on and returns the period to nominal. It takes priority over a start-of-packet pulse in the same cycle.
- R9: A start-of-packet pulse that arrives while a packet is being tracked has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 2 | Line state, bit 1 = D+, bit 0 = D- |
| sop_i | input | 1 | Start-of-packet pulse on the first K |
| eop_i | input | 1 | End-of-packet pulse |
| smp_stb_o | output | 1 | Mid-bit sample strobe |
| smp_line_o | output | 2 | Line value captured at the last mid-bit sample |
| edge_stb_o | output | 1 | Edge-point strobe |
| edge_line_o | output | 2 | Line value captured at the last edge point (or at start of packet) |
| period_o | output | CNT_W+FRAC_W | Current bit period in fixed point |

## Verification
The hardest state to reach from the ports is the clamp. It needs fifty to eighty trims in a row in the same direction. A line that is merely fast or slow drifts through the sample grid and produces a mix of shrinks, grows and missed transitions. The bench therefore drives the line in reaction to the block's own strobes. It toggles the symbol right after each mid-bit strobe to force a shrink on every bit, and right after each edge-point strobe to force a grow, which drives the period exactly onto each bound. A sweep over bit lengths of seven to nine clocks and several symbol patterns, including single-ended symbols and a stray start pulse, is checked cycle by cycle against an arithmetic model in the bench.

// File: rtl/usb_trk_pkg.sv
package usb_trk_pkg;

    localparam logic [1:0] LN_SE0 = 2'b00;
    localparam logic [1:0] LN_SE1 = 2'b11;

    localparam int unsigned FS_KHZ    = 12000;
    localparam int unsigned LS_KHZ    = 1500;
    localparam int unsigned TRIM_DIV  = 1000;
    localparam int unsigned PHASE_DIV = 100;
    localparam int unsigned SPAN_DIV  = 20;

    typedef struct packed {
        logic en;
        logic late;
    } trim_t;

    function automatic logic is_single_ended(input logic [1:0] s);
        return (s == LN_SE0) || (s == LN_SE1);
    endfunction

    function automatic int unsigned nominal_period(input int unsigned ovs_khz,
                                                   input bit low_speed,
                                                   input int unsigned frac_w);
        int unsigned bit_khz;
        bit_khz = low_speed ? LS_KHZ : FS_KHZ;
        return (ovs_khz << frac_w) / bit_khz;
    endfunction

    function automatic int unsigned period_min(input int unsigned nom);
        return nom - nom / SPAN_DIV;
    endfunction

    function automatic int unsigned period_max(input int unsigned nom);
        return nom + nom / SPAN_DIV;
    endfunction

endpackage

// File: rtl/usb_trk_judge.sv
module usb_trk_judge
    import usb_trk_pkg::*;
(
    input  logic [1:0] smp_sym,
    input  logic [1:0] last_sym,
    input  logic [1:0] edge_sym,
    output trim_t      trim
);

    always_comb begin
        trim = '0;
        if (smp_sym != last_sym && !is_single_ended(smp_sym) && !is_single_ended(edge_sym)) begin
            trim.en   = 1'b1;
            trim.late = (edge_sym != smp_sym);
        end
    end

endmodule

// File: rtl/usb_trk_period.sv
module usb_trk_period
    import usb_trk_pkg::*;
#(
    parameter int unsigned PER_W = 24,
    parameter int unsigned NOM   = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restore,
    input  trim_t            trim,
    output logic [PER_W-1:0] per_q,
    output logic [PER_W-1:0] per_nxt
);

    localparam logic [PER_W-1:0] NOM_V  = PER_W'(NOM);
    localparam logic [PER_W-1:0] PMIN_V = PER_W'(period_min(NOM));
    localparam logic [PER_W-1:0] PMAX_V = PER_W'(period_max(NOM));

    logic [PER_W-1:0] step;
    logic [PER_W-1:0] grown;
    logic [PER_W-1:0] shrunk;

    always_comb begin
        step   = per_q / PER_W'(TRIM_DIV);
        grown  = per_q + step;
        shrunk = per_q - step;
        if (restore) begin
            per_nxt = NOM_V;
        end else if (trim.en) begin
            if (trim.late) begin
                per_nxt = (grown > PMAX_V) ? PMAX_V : grown;
            end else begin
                per_nxt = (shrunk < PMIN_V) ? PMIN_V : shrunk;
            end
        end else begin
            per_nxt = per_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= NOM_V;
        end else begin
            per_q <= per_nxt;
        end
    end

endmodule

// File: rtl/usb_trk_phase.sv
module usb_trk_phase
    import usb_trk_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    stop,
    input  logic [CNT_W+FRAC_W-1:0] per_q,
    input  logic [CNT_W+FRAC_W-1:0] per_nxt,
    input  trim_t                   trim,
    output logic                    trk,
    output logic                    smp_hit,
    output logic                    edge_hit
);

    localparam int unsigned    POS_W = CNT_W + FRAC_W;
    localparam logic [POS_W-1:0] HALF = POS_W'(1) << (FRAC_W - 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_adv;
    logic [POS_W-1:0] pos_nxt;
    logic [POS_W-1:0] pos_start;
    logic [POS_W-1:0] edge_fix;
    logic [POS_W-1:0] step;
    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] edge_pt_q;
    logic             armed_q;
    logic             trk_q;

    always_comb begin
        step      = per_nxt / POS_W'(PHASE_DIV);
        pos_adv   = pos_q + per_q;
        edge_fix  = pos_adv - (per_q >> 1);
        pos_start = {now_q, {FRAC_W{1'b0}}} - (per_q >> 1) + HALF + per_q;
        if (trim.en) begin
            pos_nxt = trim.late ? (pos_adv + step) : (pos_adv - step);
        end else begin
            pos_nxt = pos_adv;
        end
    end

    assign trk      = trk_q;
    assign smp_hit  = trk_q && !stop && (pos_q[POS_W-1:FRAC_W] == now_q);
    assign edge_hit = trk_q && !stop && armed_q && (edge_pt_q == now_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q     <= '0;
            pos_q     <= '0;
            edge_pt_q <= '0;
            armed_q   <= 1'b0;
            trk_q     <= 1'b0;
        end else begin
            now_q <= now_q + 1'b1;
            if (stop) begin
                trk_q   <= 1'b0;
                armed_q <= 1'b0;
            end else if (start) begin
                trk_q   <= 1'b1;
                armed_q <= 1'b0;
                pos_q   <= pos_start;
            end else if (trk_q) begin
                if (edge_hit) begin
                    armed_q <= 1'b0;
                end
                if (smp_hit) begin
                    edge_pt_q <= edge_fix[POS_W-1:FRAC_W];
                    armed_q   <= 1'b1;
                    pos_q     <= pos_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/usb_bit_tracker.sv
module usb_bit_tracker
    import usb_trk_pkg::*;
#(
    parameter int unsigned OVS_KHZ   = 96000,
    parameter bit          LOW_SPEED = 1'b0,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned FRAC_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              line_i,
    input  logic                    sop_i,
    input  logic                    eop_i,
    output logic                    smp_stb_o,
    output logic [1:0]              smp_line_o,
    output logic                    edge_stb_o,
    output logic [1:0]              edge_line_o,
    output logic [CNT_W+FRAC_W-1:0] period_o
);

    localparam int unsigned PER_W = CNT_W + FRAC_W;
    localparam int unsigned NOM   = nominal_period(OVS_KHZ, LOW_SPEED, FRAC_W);

    logic             trk;
    logic             smp_hit;
    logic             edge_hit;
    logic             start;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] per_nxt;
    logic [1:0]       last_q;
    logic [1:0]       edge_q;
    logic [1:0]       sline_q;
    logic             sstb_q;
    logic             estb_q;
    trim_t            judged;
    trim_t            trim_g;

    assign start = sop_i && !eop_i && !trk;

    usb_trk_judge u_judge (
        .smp_sym  (line_i),
        .last_sym (last_q),
        .edge_sym (edge_q),
        .trim     (judged)
    );

    always_comb begin
        trim_g      = judged;
        trim_g.en   = judged.en && smp_hit;
    end

    usb_trk_period #(
        .PER_W (PER_W),
        .NOM   (NOM)
    ) u_period (
        .clk     (clk),
        .rst     (rst),
        .restore (eop_i),
        .trim    (trim_g),
        .per_q   (per_q),
        .per_nxt (per_nxt)
    );

    usb_trk_phase #(
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (eop_i),
        .per_q    (per_q),
        .per_nxt  (per_nxt),
        .trim     (trim_g),
        .trk      (trk),
        .smp_hit  (smp_hit),
        .edge_hit (edge_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= 2'b00;
            edge_q  <= 2'b00;
            sline_q <= 2'b00;
            sstb_q  <= 1'b0;
            estb_q  <= 1'b0;
        end else begin
            sstb_q <= smp_hit;
            estb_q <= edge_hit;
            if (start) begin
                last_q <= line_i;
                edge_q <= line_i;
            end
            if (edge_hit) begin
                edge_q <= line_i;
            end
            if (smp_hit) begin
                sline_q <= line_i;
                last_q  <= line_i;
            end
        end
    end

    assign smp_stb_o   = sstb_q;
    assign smp_line_o  = sline_q;
    assign edge_stb_o  = estb_q;
    assign edge_line_o = edge_q;
    assign period_o    = per_q;

endmodule

// File: rtl/usb_bit_tracker_chk.sv
module usb_bit_tracker_chk
    import usb_trk_pkg::*;
#(
    parameter int unsigned OVS_KHZ   = 96000,
    parameter bit          LOW_SPEED = 1'b0,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned FRAC_W    = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    eop_i,
    input logic                    smp_stb_o,
    input logic [1:0]              smp_line_o,
    input logic                    edge_stb_o,
    input logic [CNT_W+FRAC_W-1:0] period_o
);

    localparam int unsigned PER_W = CNT_W + FRAC_W;
    localparam int unsigned NOM   = nominal_period(OVS_KHZ, LOW_SPEED, FRAC_W);
    localparam logic [PER_W-1:0] NOM_V  = PER_W'(NOM);
    localparam logic [PER_W-1:0] PMIN_V = PER_W'(period_min(NOM));
    localparam logic [PER_W-1:0] PMAX_V = PER_W'(period_max(NOM));

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!smp_stb_o && !edge_stb_o && period_o == NOM_V));

    // R3
    a_r3_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        !(smp_stb_o && edge_stb_o));

    // R6
    a_r6_trim_only_at_sample: assert property (@(posedge clk) disable iff (rst)
        (period_o != $past(period_o)) |-> (smp_stb_o || $past(eop_i)));

    // R6
    a_r6_single_ended_no_trim: assert property (@(posedge clk) disable iff (rst)
        (smp_stb_o && is_single_ended(smp_line_o)) |-> (period_o == $past(period_o)));

    // R7
    a_r7_period_bounds: assert property (@(posedge clk) disable iff (rst)
        (period_o >= PMIN_V) && (period_o <= PMAX_V));

    // R8
    a_r8_eop_restore: assert property (@(posedge clk) disable iff (rst)
        eop_i |=> (period_o == NOM_V && !smp_stb_o && !edge_stb_o));

endmodule

bind usb_bit_tracker usb_bit_tracker_chk #(
    .OVS_KHZ   (OVS_KHZ),
    .LOW_SPEED (LOW_SPEED),
    .CNT_W     (CNT_W),
    .FRAC_W    (FRAC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .eop_i      (eop_i),
    .smp_stb_o  (smp_stb_o),
    .smp_line_o (smp_line_o),
    .edge_stb_o (edge_stb_o),
    .period_o   (period_o)
);

// File: tb/tb_usb_bit_tracker.sv
module tb_usb_bit_tracker;

    localparam int NOM  = 2048;
    localparam int PMIN = NOM - NOM / 20;
    localparam int PMAX = NOM + NOM / 20;
    localparam logic [1:0] LJ = 2'b10;
    localparam logic [1:0] LK = 2'b01;
    localparam logic [1:0] L0 = 2'b00;
    localparam logic [1:0] L1 = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  drv_line = LJ;
    logic        drv_sop = 1'b0;
    logic        drv_eop = 1'b0;
    logic        smp_stb_o;
    logic [1:0]  smp_line_o;
    logic        edge_stb_o;
    logic [1:0]  edge_line_o;
    logic [23:0] period_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    usb_bit_tracker dut (
        .clk         (clk),
        .rst         (rst),
        .line_i      (drv_line),
        .sop_i       (drv_sop),
        .eop_i       (drv_eop),
        .smp_stb_o   (smp_stb_o),
        .smp_line_o  (smp_line_o),
        .edge_stb_o  (edge_stb_o),
        .edge_line_o (edge_line_o),
        .period_o    (period_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit se(input logic [1:0] s);
        return (s == L0) || (s == L1);
    endfunction

    // Arithmetic model of the requirements, stepped on the same edges.
    logic [15:0] m_now, m_edge_pt;
    logic [23:0] m_pos;
    int          m_per;
    bit          m_trk, m_armed, m_sstb, m_estb;
    logic [1:0]  m_last, m_eline, m_sline;

    always @(posedge clk) begin
        bit          hs, he;
        int          pn;
        logic [23:0] st, tmp;
        logic [1:0]  ln;
        if (rst) begin
            m_now = '0; m_edge_pt = '0; m_pos = '0; m_per = NOM;
            m_trk = 0; m_armed = 0; m_sstb = 0; m_estb = 0;
            m_last = L0; m_eline = L0; m_sline = L0;
        end else begin
            ln = drv_line; hs = 0; he = 0;
            if (drv_eop) begin
                m_trk = 0; m_armed = 0; m_per = NOM;
            end else if (!m_trk) begin
                if (drv_sop) begin
                    m_trk = 1; m_armed = 0;
                    m_pos = {m_now, 8'h00} - 24'(m_per / 2) + 24'd128 + 24'(m_per);
                    m_last = ln; m_eline = ln;
                end
            end else begin
                if (m_armed && m_edge_pt == m_now) begin
                    he = 1; m_armed = 0; m_eline = ln;
                end
                if (m_pos[23:8] == m_now) begin
                    hs = 1;
                    tmp = m_pos + 24'(m_per - m_per / 2);
                    m_edge_pt = tmp[23:8];
                    m_armed = 1;
                    pn = m_per;
                    tmp = m_pos + 24'(m_per);
                    if (ln != m_last && !se(ln) && !se(m_eline)) begin
                        if (m_eline == ln) begin
                            pn = m_per - m_per / 1000;
                            if (pn < PMIN) pn = PMIN;
                            st = 24'(pn / 100);
                            tmp = tmp - st;
                        end else begin
                            pn = m_per + m_per / 1000;
                            if (pn > PMAX) pn = PMAX;
                            st = 24'(pn / 100);
                            tmp = tmp + st;
                        end
                    end
                    m_pos = tmp; m_per = pn; m_last = ln; m_sline = ln;
                end
            end
            m_sstb = hs; m_estb = he;
            m_now = m_now + 16'd1;
        end
    end

    // Lockstep comparison of every output (R3, R4, R5, R9 timing and values).
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({smp_stb_o, edge_stb_o, smp_line_o, edge_line_o, period_o} ==
                  {m_sstb, m_estb, m_sline, m_eline, 24'(m_per)},
                  "R3 R4 R5 R9 lockstep outputs",
                  {smp_stb_o, edge_stb_o, smp_line_o, edge_line_o, period_o},
                  {m_sstb, m_estb, m_sline, m_eline, 24'(m_per)});
        end
    end

    function automatic logic [1:0] sym_of(input int pat, input int b);
        case (pat)
            0: return (b % 2 == 1) ? LJ : LK;
            1: return ((b / 3) % 2 == 1) ? LJ : LK;
            2: return (b % 5 == 4) ? L1 : ((b % 2 == 1) ? LJ : LK);
            default: return LK;
        endcase
    endfunction

    task automatic eop_seq(input int len);
        for (int c = 0; c < 2 * len; c++) begin
            @(negedge clk); drv_line = L0; drv_sop = 0; drv_eop = 0;
        end
        @(negedge clk); drv_line = LJ; drv_eop = 1;
        @(negedge clk); drv_eop = 0;
        // R8: period back to nominal, no strobe after the pulse
        check(period_o == 24'(NOM), "R8 period restored", period_o, NOM);
        check(!smp_stb_o && !edge_stb_o, "R8 strobes stopped", {smp_stb_o, edge_stb_o}, 0);
        for (int c = 0; c < 2 * len; c++) @(negedge clk);
    endtask

    task automatic send(input int len, input int pat, input int nbits, input bit xsop,
                        output int p_data);
        int d;
        d = (NOM - NOM / 2 + 128) / 256;
        for (int b = 0; b < nbits; b++) begin
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                if (b == 0 && c == d) check(smp_stb_o == 1'b0, "R2 no early sample", smp_stb_o, 0);
                if (b == 0 && c == d + 1) check(smp_stb_o == 1'b1, "R2 first sample", smp_stb_o, 1);
                drv_line = sym_of(pat, b);
                drv_sop  = (c == 0) && (b == 0 || (xsop && b == 10));
                drv_eop  = 0;
            end
        end
        p_data = int'(period_o);
        eop_seq(len);
    endtask

    task automatic react(input int mode, input int nsmp, output int p2, output int pend);
        int         seen;
        logic [1:0] cur;
        seen = 0; cur = LK; p2 = 0;
        @(negedge clk); drv_line = LK; drv_sop = 1; drv_eop = 0;
        while (seen < nsmp) begin
            @(negedge clk);
            drv_sop = 0;
            if (smp_stb_o) begin
                seen++;
                if (seen == 2) p2 = int'(period_o);
            end
            if ((mode == 0 && smp_stb_o) || (mode == 1 && edge_stb_o)) begin
                cur = (cur == LK) ? LJ : LK;
                drv_line = cur;
            end
        end
        pend = int'(period_o);
        eop_seq(8);
    endtask

    initial begin
        int p, p2, pe;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(!smp_stb_o && !edge_stb_o, "R1 strobes low after reset", {smp_stb_o, edge_stb_o}, 0);
        check(period_o == 24'(NOM), "R1 nominal period", period_o, NOM);

        for (int len = 7; len <= 9; len++) begin
            for (int pat = 0; pat < 4; pat++) begin
                send(len, pat, 24, 1'b0, p);
                // R6: a packet without symbol changes leaves the period alone
                if (pat == 3) check(p == NOM, "R6 no change without transitions", p, NOM);
            end
        end

        // R9: stray start pulse inside a packet, checked by the lockstep compare
        send(8, 0, 30, 1'b1, p);

        // R4 and R7: toggle after each sample so every edge point sees the new symbol
        react(0, 120, p2, pe);
        check(p2 == NOM - NOM / 1000, "R4 period shrinks", p2, NOM - NOM / 1000);
        check(pe == PMIN, "R7 lower clamp", pe, PMIN);

        // R5 and R7: toggle after each edge point so it sees the old symbol
        react(1, 120, p2, pe);
        check(p2 == NOM + NOM / 1000, "R5 period grows", p2, NOM + NOM / 1000);
        check(pe == PMAX, "R7 upper clamp", pe, PMAX);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule